// File: doc/BRIEF.md
# ASCII Hex Record Loader

This block takes a stream of ASCII characters, one byte per accepted transfer, and turns text records into byte writes to an internal memory. A record spans two lines. The first line names a start address and a byte count. The second line lists that many bytes as hexadecimal text. Each decoded byte is written to the next address in ascending order, beginning at the start address.

Text that follows the count on the first line is commentary and is skipped. Text after the final byte's trailing space on the second line is also skipped. A malformed digit or separator raises a sticky error flag. Characters are then dropped until the next line feed, and the line after it is read as a fresh header.

A read port exposes the memory so that the loaded contents can be inspected.

Top module: `hexrec_loader`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears `err_flag` and `wr_en`, holds `in_ready` low, and leaves the parser waiting for the first address digit of a header. `in_ready` rises on the first edge after `rst` falls.
- R2: A header is exactly ADDR_W/4 uppercase hex digits (most significant first), then one space (0x20), then a single hex count digit N. Every character after N up to the line feed (0x0A) is ignored, even if it looks like hex.
- R3: The line after a header carries N bytes. Each byte is two hex digits, high nibble first. Byte k (counting from 0) goes to the header address plus k, modulo 2^ADDR_W.
- R4: Each completed byte produces `wr_en` high for exactly one cycle, with `wr_addr` and `wr_data` valid. This is the cycle after the edge that accepts the byte's second digit.
- R5: After the Nth byte, exactly one space is expected. Every later character up to the line feed causes no write and no error, and the next line is read as a header.
- R6: A carriage return (0x0D) is ignored in every parser state and changes nothing.
- R7: Digits map '0'..'9' to 0..9 and 'A'..'F' to 10..15. Any other character where a digit is expected sets `err_flag`: this includes ':' through '@', lowercase letters, space and line feed. The flag stays set until reset. Characters are then discarded up to a line feed, and the next line is a header.
- R8: A count digit of 0, a non-space after the address, or a non-space after a data byte is an error handled as in R7.
- R9: `rd_data` shows the byte most recently written to address `rd_addr`. The memory is addressed by the low MEM_AW bits of `wr_addr`.
- R10: A character is consumed only on an edge where `in_valid` and `in_ready` are both high. Cycles without a transfer produce no write and no state change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Character on `in_char` is offered |
| in_ready | output | 1 | Loader accepts a character this cycle |
| in_char | input | 8 | ASCII character |
| wr_en | output | 1 | One-cycle write strobe per decoded byte |
| wr_addr | output | ADDR_W (16) | Full byte address of the current write |
| wr_data | output | 8 | Decoded byte of the current write |
| err_flag | output | 1 | Sticky format error indication |
| rd_addr | input | MEM_AW (10) | Memory read address |
| rd_data | output | 8 | Memory contents at `rd_addr` |

## Verification
The checks on the write strobe assume that a byte always costs at least three accepted characters (two digits and a space), so strobes never occur back to back. The stimulus respects this because it is built only from text lines.

The read-after-write property assumes `rd_addr` is held for the cycle after a matching write. The bench moves `rd_addr` only while no characters flow.

Idle gaps on `in_valid` are inserted between characters of some records, so that the no-transfer rule is exercised in the middle of headers and bytes. The bench never offers a character while `rst` is high.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

   localparam logic [7:0] CH_LF    = 8'h0A;
   localparam logic [7:0] CH_CR    = 8'h0D;
   localparam logic [7:0] CH_SP    = 8'h20;
   localparam logic [7:0] CH_ZERO  = 8'h30;
   localparam logic [7:0] CH_UPPER = 8'h46;  // last table entry ('F')
   localparam int         TBL_SPAN = 23;     // '0' .. 'F' inclusive

   typedef enum logic [3:0] {
      PS_ADDR,   // collecting address digits
      PS_SEP,    // space between address and count
      PS_CNT,    // single count digit
      PS_HSKIP,  // header commentary up to line feed
      PS_DHI,    // high nibble of a data byte
      PS_DLO,    // low nibble of a data byte
      PS_DSP,    // space after a data byte
      PS_DSKIP,  // data-line commentary up to line feed
      PS_DROP    // discarding after a format error
   } pstate_e;

endpackage

// File: rtl/hexrec_digit.sv
module hexrec_digit
   import hexrec_pkg::*;
(
   input  logic [7:0] ch,
   output logic       dig_ok,
   output logic [3:0] dig_val,
   output logic       is_lf,
   output logic       is_cr,
   output logic       is_sp
);

   // 32-slot lookup indexed by (ch - '0'); slots past the span are invalid
   logic [4:0] tbl [32];

   for (genvar gi = 0; gi < 32; gi++) begin : g_tbl
      if (gi < 10) begin : g_num
         assign tbl[gi] = {1'b1, 4'(gi)};
      end else if (gi >= 17 && gi < TBL_SPAN) begin : g_alpha
         assign tbl[gi] = {1'b1, 4'(gi - 7)};
      end else begin : g_bad
         assign tbl[gi] = 5'b0_0000;
      end
   end

   logic       in_span;
   logic [4:0] off;
   logic [4:0] entry;

   assign in_span = (ch >= CH_ZERO) && (ch <= CH_UPPER);
   assign off     = 5'(ch - CH_ZERO);
   assign entry   = in_span ? tbl[off] : 5'b0_0000;

   assign dig_ok  = entry[4];
   assign dig_val = entry[3:0];
   assign is_lf   = (ch == CH_LF);
   assign is_cr   = (ch == CH_CR);
   assign is_sp   = (ch == CH_SP);

endmodule

// File: rtl/hexrec_parser.sv
module hexrec_parser
   import hexrec_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              acc,
   input  logic              dig_ok,
   input  logic [3:0]        dig_val,
   input  logic              is_lf,
   input  logic              is_cr,
   input  logic              is_sp,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              err_flag
);

   localparam int ADDR_DIGITS = ADDR_W / 4;
   localparam int DC_W        = (ADDR_DIGITS > 1) ? $clog2(ADDR_DIGITS) : 1;
   localparam logic [DC_W-1:0] DC_LAST = DC_W'(ADDR_DIGITS - 1);

   pstate_e           st;
   logic [ADDR_W-1:0] addr;
   logic [DC_W-1:0]   dcnt;
   logic [3:0]        remain;
   logic [3:0]        hi_nib;

   always_ff @(posedge clk) begin
      if (rst) begin
         st       <= PS_ADDR;
         err_flag <= 1'b0;
         wr_en    <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
         addr     <= '0;
         dcnt     <= '0;
         remain   <= '0;
         hi_nib   <= '0;
      end else begin
         wr_en <= 1'b0;
         if (acc && !is_cr) begin
            unique case (st)
               PS_ADDR: begin
                  if (dig_ok) begin
                     addr <= {addr[ADDR_W-5:0], dig_val};
                     if (dcnt == DC_LAST) begin
                        dcnt <= '0;
                        st   <= PS_SEP;
                     end else begin
                        dcnt <= dcnt + 1'b1;
                     end
                  end else begin
                     err_flag <= 1'b1;
                     dcnt     <= '0;
                     st       <= PS_DROP;
                  end
               end
               PS_SEP: begin
                  if (is_sp) begin
                     st <= PS_CNT;
                  end else begin
                     err_flag <= 1'b1;
                     st       <= PS_DROP;
                  end
               end
               PS_CNT: begin
                  if (dig_ok && dig_val != 4'd0) begin
                     remain <= dig_val;
                     st     <= PS_HSKIP;
                  end else begin
                     err_flag <= 1'b1;
                     st       <= PS_DROP;
                  end
               end
               PS_HSKIP: begin
                  if (is_lf) st <= PS_DHI;
               end
               PS_DHI: begin
                  if (dig_ok) begin
                     hi_nib <= dig_val;
                     st     <= PS_DLO;
                  end else begin
                     err_flag <= 1'b1;
                     st       <= PS_DROP;
                  end
               end
               PS_DLO: begin
                  if (dig_ok) begin
                     wr_en   <= 1'b1;
                     wr_addr <= addr;
                     wr_data <= {hi_nib, dig_val};
                     addr    <= addr + ADDR_W'(1);
                     remain  <= remain - 4'd1;
                     st      <= PS_DSP;
                  end else begin
                     err_flag <= 1'b1;
                     st       <= PS_DROP;
                  end
               end
               PS_DSP: begin
                  if (is_sp) begin
                     st <= (remain == 4'd0) ? PS_DSKIP : PS_DHI;
                  end else begin
                     err_flag <= 1'b1;
                     st       <= PS_DROP;
                  end
               end
               PS_DSKIP, PS_DROP: begin
                  if (is_lf) st <= PS_ADDR;
               end
               default: begin
                  err_flag <= 1'b1;
                  st       <= PS_DROP;
               end
            endcase
         end
      end
   end

   // R7: once raised, the error flag persists until reset
   a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
      err_flag |=> err_flag);

   // R6: a carriage return leaves the parser state untouched
   a_r6_cr_no_move: assert property (@(posedge clk) disable iff (rst)
      (acc && is_cr) |=> $stable(st));

   // R5: no write strobe while skipping data-line commentary
   a_r5_quiet_skip: assert property (@(posedge clk) disable iff (rst)
      (st == PS_DSKIP) |-> !wr_en);

   // R4: a byte needs two digits and a space, so strobes never abut
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> !wr_en);

   // R2: header commentary is only reached with a nonzero count loaded
   a_r2_count_nonzero: assert property (@(posedge clk) disable iff (rst)
      (st == PS_HSKIP) |-> (remain != 4'd0));

endmodule

// File: rtl/hexrec_mem.sv
module hexrec_mem #(
   parameter int AW       = 10,
   parameter int DW       = 8,
   parameter bit READ_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   if (READ_REG) begin : g_rd_reg
      always_ff @(posedge clk) begin
         rdata <= mem[raddr];
      end
   end else begin : g_rd_comb
      assign rdata = mem[raddr];

      // R9: a held read address shows the byte just written there
      a_r9_read_after_write: assert property (@(posedge clk) disable iff (rst)
         (we && raddr == waddr) ##1 $stable(raddr) |-> (rdata == $past(wdata)));
   end

endmodule

// File: rtl/hexrec_loader.sv
module hexrec_loader #(
   parameter int ADDR_W   = 16,
   parameter int MEM_AW   = 10,
   parameter bit READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [7:0]        in_char,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              err_flag,
   input  logic [MEM_AW-1:0] rd_addr,
   output logic [7:0]        rd_data
);

   if (ADDR_W < 8 || (ADDR_W % 4) != 0) begin : g_bad_addr_w
      $error("hexrec_loader: ADDR_W must be a multiple of 4 and at least 8");
   end
   if (MEM_AW < 1 || MEM_AW > ADDR_W || MEM_AW > 16) begin : g_bad_mem_aw
      $error("hexrec_loader: MEM_AW must lie in 1..min(ADDR_W,16)");
   end

   logic       rdy_q;
   logic       acc;
   logic       dig_ok;
   logic [3:0] dig_val;
   logic       is_lf;
   logic       is_cr;
   logic       is_sp;

   always_ff @(posedge clk) begin
      rdy_q <= !rst;
   end

   assign in_ready = rdy_q;
   assign acc      = in_valid && rdy_q;

   hexrec_digit u_digit (
      .ch      (in_char),
      .dig_ok  (dig_ok),
      .dig_val (dig_val),
      .is_lf   (is_lf),
      .is_cr   (is_cr),
      .is_sp   (is_sp)
   );

   hexrec_parser #(.ADDR_W(ADDR_W)) u_parser (
      .clk      (clk),
      .rst      (rst),
      .acc      (acc),
      .dig_ok   (dig_ok),
      .dig_val  (dig_val),
      .is_lf    (is_lf),
      .is_cr    (is_cr),
      .is_sp    (is_sp),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .err_flag (err_flag)
   );

   hexrec_mem #(.AW(MEM_AW), .DW(8), .READ_REG(READ_REG)) u_mem (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_en),
      .waddr (wr_addr[MEM_AW-1:0]),
      .wdata (wr_data),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   // R10: an edge without a transfer yields no write in the next cycle
   a_r10_idle_no_write: assert property (@(posedge clk) disable iff (rst)
      !(in_valid && in_ready) |=> !wr_en);

   // R1: leaving reset presents a clean, error-free interface
   a_r1_clean_exit: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!wr_en && !err_flag && !in_ready));

endmodule

// File: tb/sim_hexrec_loader.sv
module sim_hexrec_loader;

   localparam int ADDR_W = 16;
   localparam int MEM_AW = 10;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [7:0]        in_char = 8'h00;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [7:0]        wr_data;
   logic              err_flag;
   logic [MEM_AW-1:0] rd_addr = '0;
   logic [7:0]        rd_data;

   always #4 clk = ~clk;   // 8 ns period

   hexrec_loader #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_char(in_char), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .err_flag(err_flag), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    done     = 1'b0;
   bit    gap_mode = 1'b0;
   string cur_tag  = "R3";

   // behavioural reference model state
   localparam int M_HEAD = 0, M_SEP = 1, M_CNT = 2, M_HSK = 3, M_HI = 4,
                  M_LO = 5, M_SP = 6, M_DSK = 7, M_BAD = 8;
   int          m_st;
   int          m_dig;
   logic [15:0] m_addr;
   int          m_cnt;
   int          m_hi;
   bit          exp_wr;
   logic [15:0] exp_addr;
   logic [7:0]  exp_data;
   bit          exp_err;
   logic [7:0]  exp_mem [int];

   function automatic int hexval(input logic [7:0] c);
      if (c >= "0" && c <= "9") return int'(c) - 48;
      if (c >= "A" && c <= "F") return int'(c) - 55;
      return -1;
   endfunction

   task automatic model_reset();
      m_st = M_HEAD; m_dig = 0; m_addr = '0; m_cnt = 0; m_hi = 0;
      exp_wr = 1'b0; exp_err = 1'b0;
   endtask

   task automatic model_fault();
      exp_err = 1'b1;
      m_st    = M_BAD;
      m_dig   = 0;
   endtask

   task automatic model_step(input logic [7:0] c);
      int v;
      exp_wr = 1'b0;
      if (c == 8'h0D) return;
      v = hexval(c);
      case (m_st)
         M_HEAD: if (v >= 0) begin
                    m_addr = {m_addr[11:0], v[3:0]};
                    m_dig++;
                    if (m_dig == 4) begin m_dig = 0; m_st = M_SEP; end
                 end else model_fault();
         M_SEP:  if (c == 8'h20) m_st = M_CNT; else model_fault();
         M_CNT:  if (v > 0) begin m_cnt = v; m_st = M_HSK; end else model_fault();
         M_HSK:  if (c == 8'h0A) m_st = M_HI;
         M_HI:   if (v >= 0) begin m_hi = v; m_st = M_LO; end else model_fault();
         M_LO:   if (v >= 0) begin
                    exp_wr   = 1'b1;
                    exp_addr = m_addr;
                    exp_data = {m_hi[3:0], v[3:0]};
                    exp_mem[int'(m_addr[MEM_AW-1:0])] = exp_data;
                    m_addr++;
                    m_cnt--;
                    m_st = M_SP;
                 end else model_fault();
         M_SP:   if (c == 8'h20) m_st = (m_cnt == 0) ? M_DSK : M_HI; else model_fault();
         default: if (c == 8'h0A) m_st = M_HEAD;   // M_DSK and M_BAD
      endcase
   endtask

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // one clock: drive at negedge, model at posedge, compare at next negedge
   task automatic tick(input bit v, input logic [7:0] c);
      in_valid = v;
      in_char  = c;
      @(posedge clk);
      if (v) model_step(c); else exp_wr = 1'b0;
      @(negedge clk);
      check(wr_en === exp_wr, (v ? cur_tag : "R10"), "wr_en", 32'(wr_en), 32'(exp_wr));
      if (exp_wr) begin
         check(wr_addr === exp_addr, "R3", "wr_addr", 32'(wr_addr), 32'(exp_addr));
         check(wr_data === exp_data, "R4", "wr_data", 32'(wr_data), 32'(exp_data));
      end
      check(err_flag === exp_err, (exp_err ? "R7" : cur_tag), "err_flag",
            32'(err_flag), 32'(exp_err));
      check(in_ready === 1'b1, "R10", "in_ready", 32'(in_ready), 32'd1);
   endtask

   task automatic send(input string s);
      for (int i = 0; i < s.len(); i++) begin
         tick(1'b1, s[i]);
         if (gap_mode) tick(1'b0, 8'h00);
      end
      tick(1'b0, 8'h00);
   endtask

   task automatic check_mem(input logic [15:0] a, input logic [7:0] e, input string tag);
      rd_addr = a[MEM_AW-1:0];
      #1;
      check(rd_data === e, tag, "rd_data", 32'(rd_data), 32'(e));
   endtask

   task automatic do_reset();
      rst      = 1'b1;
      in_valid = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      check(wr_en === 1'b0, "R1", "wr_en in reset", 32'(wr_en), 32'd0);
      check(err_flag === 1'b0, "R1", "err_flag in reset", 32'(err_flag), 32'd0);
      check(in_ready === 1'b0, "R1", "in_ready in reset", 32'(in_ready), 32'd0);
      rst = 1'b0;
      model_reset();
      @(posedge clk);
      @(negedge clk);
      check(in_ready === 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'd1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog: actual still running expected finished");
      finish_run();
   end

   initial begin
      model_reset();
      @(negedge clk);
      do_reset();

      // R2 R3 R4: worked example with hex-looking commentary
      cur_tag = "R2";
      send("12AC 7 AB CD comment\n");
      cur_tag = "R3";
      send("AE 03 B6 91 C7 00 0C trailing 55 66\n");
      check_mem(16'h12AC, 8'hAE, "R3");
      check_mem(16'h12AF, 8'h91, "R3");
      check_mem(16'h12B2, 8'h0C, "R3");

      // R5: surplus bytes after the count are not written
      cur_tag = "R5";
      send("0700 1 one\n");
      send("55 66 77\n");
      check_mem(16'h0700, 8'h55, "R5");

      // R6: carriage returns sprinkled through a record
      cur_tag = "R6";
      send("00\rF0 3 cr\r\n");
      send("F\rF 80\r 7E \r\n");
      check_mem(16'h00F1, 8'h80, "R6");

      // R10: idle cycles between every character
      cur_tag = "R10";
      gap_mode = 1'b1;
      send("03FE 2 g\n");
      send("5A A5 \n");
      gap_mode = 1'b0;
      check_mem(16'h03FE, 8'h5A, "R10");

      // R9: address wrap at the top of the 16-bit space, memory aliasing
      cur_tag = "R9";
      send("FFFF 2 w\n");
      send("11 22 \n");
      check_mem(16'hFFFF, 8'h11, "R9");
      check_mem(16'h0000, 8'h22, "R9");

      // R7: invalid digits, sticky flag, recovery on the next header
      cur_tag = "R7";
      send("0A:0 1 bad\n");
      send("0100 2 ok\n");
      send("AB CD \n");
      check_mem(16'h0100, 8'hAB, "R7");
      send("0200 2 lower\n");
      send("1a 22 \n");
      send("0210 1 ok\n");
      send("3C \n");
      check_mem(16'h0210, 8'h3C, "R7");

      // R8: zero count, missing separators
      do_reset();
      cur_tag = "R8";
      send("0400 0 zero\n");
      do_reset();
      send("05001 2\n");
      do_reset();
      send("0600 2 c\n");
      send("12-34 \n");
      send("0610 1 c\n");
      send("9D \n");
      check_mem(16'h0610, 8'h9D, "R8");

      // R1: reset in the middle of a data line, then a clean record
      cur_tag = "R1";
      send("0620 3 c\n");
      send("44 ");
      do_reset();
      send("0630 1 c\n");
      send("E7 \n");
      check_mem(16'h0630, 8'hE7, "R1");

      // R9: every byte the model wrote is readable
      foreach (exp_mem[a]) check_mem(16'(a), exp_mem[a], "R9");

      finish_run();
   end

endmodule